// File: doc/BRIEF.md
# Watchdog Timer with Write-Only Mode Register

This block guards a processor core against a hung program. A counter advances on each pulse of a millisecond-rate tick input. If software neither refreshes the timer nor rewrites its mode register before the selected period has passed, the block raises a reset request for one clock. The counter then restarts, and the mode register falls back to its power-on value.

An 8-bit mode register, which can only be written, sets three things. Its low two bits choose a fine period. Bits [6:4] form a one-hot field that selects a coarse period. Two further bits decide whether counting goes on while the core reports HALT or STOP. The tick count for each of the seven periods is a parameter, so a system can match its own time base and a bench can scale time down.

A status flag tells the last reset cause. It is 1 after a stop-mode recovery and 0 after a power-on or watchdog reset. A stop-mode recovery leaves the mode register as it was.

Top module: `wdog_top`

## Requirements
- R1: While `por_rst` is high, and on the first cycle after it falls, `wdt_rst_req` and `smr_flag` are 0. The mode register takes 0x0D: HALT and STOP counting on, fine code 01, which gives period `TICKS_1`.
- R2: When mode bits [6:4] are 000, bits [1:0] choose the period: 00 gives `TICKS_0`, 01 gives `TICKS_1`, 10 gives `TICKS_2` and 11 gives `TICKS_3` ticks.
- R3: When mode bits [6:4] are 001, 010 or 100, the period is `TICKS_4`, `TICKS_5` or `TICKS_6`, and bits [1:0] have no effect.
- R4: When two or three of mode bits [6:4] are set, the period comes from bits [1:0] alone, as in R2.
- R5: When mode bit 2 is 0 and `halt_st` is high, ticks do not advance the counter. When bit 2 is 1, ticks advance it during HALT.
- R6: When mode bit 3 is 0 and `stop_st` is high, ticks do not advance the counter. When bit 3 is 1, ticks advance it during STOP.
- R7: A `kick` pulse clears the counter, so a full period of ticks is again needed before expiry.
- R8: A write to the mode register clears the counter. Mode bit 7 is ignored.
- R9: On the tick that brings the count to the selected period, `wdt_rst_req` goes high on the next cycle for exactly one cycle. The counter restarts from zero, `smr_flag` clears and the mode register returns to 0x0D.
- R10: A `smr_pulse` sets `smr_flag` to 1 and leaves the mode register and the period unchanged.
- R11: The counter advances only on cycles with `ms_tick` high. No expiry happens without a tick on the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on / brown-out reset |
| smr_pulse | input | 1 | One-cycle stop-mode-recovery event |
| ms_tick | input | 1 | One-cycle time-base pulse |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| kick | input | 1 | Refresh strobe |
| halt_st | input | 1 | Core is in HALT |
| stop_st | input | 1 | Core is in STOP |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| smr_flag | output | 1 | 1 when the last reset came from stop-mode recovery |

## Verification
The bench builds the block with tick counts of 3 to 9 for the seven periods. Every period code, including the multi-bit coarse fallback, then expires within a few dozen cycles, and the longest coarse period can be measured tick by tick against a behavioural model. These short periods also let the bench run the HALT and STOP hold tests, refreshes in the middle of a period, and the return to 0x0D after an expiry in a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NPER = 7;
  typedef logic [2:0] per_idx_t;

  // Decode the 7 writable mode bits into a period index 0..6.
  function automatic per_idx_t decode_period(input logic [6:0] m);
    per_idx_t r;
    unique case (m[6:4])
      3'b001:  r = 3'd4;
      3'b010:  r = 3'd5;
      3'b100:  r = 3'd6;
      default: r = {1'b0, m[1:0]};
    endcase
    return r;
  endfunction

  function automatic int unsigned max7(input int unsigned a, b, c, d, e, f, g);
    int unsigned x;
    x = a;
    if (b > x) x = b;
    if (c > x) x = c;
    if (d > x) x = d;
    if (e > x) x = e;
    if (f > x) x = f;
    if (g > x) x = g;
    return x;
  endfunction
endpackage

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
  import wdog_pkg::*;
#(
  parameter logic [6:0] RST_VAL = 7'h0D
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output per_idx_t   per_idx,
  output logic       halt_en,
  output logic       stop_en
);
  logic [6:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)     mode_q <= RST_VAL;
    else if (we) mode_q <= wdata[6:0];
  end

  assign per_idx = decode_period(mode_q);
  assign halt_en = mode_q[2];
  assign stop_en = mode_q[3];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q >= (limit - CW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (step) begin
        if (last) begin
          cnt_q  <= '0;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic por,
  input  logic wdt_evt,
  input  logic smr_evt,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (por || wdt_evt) flag <= 1'b0;
    else if (smr_evt)   flag <= 1'b1;
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned TICKS_0 = 5,
  parameter int unsigned TICKS_1 = 10,
  parameter int unsigned TICKS_2 = 20,
  parameter int unsigned TICKS_3 = 80,
  parameter int unsigned TICKS_4 = 320,
  parameter int unsigned TICKS_5 = 1280,
  parameter int unsigned TICKS_6 = 5120
) (
  input  logic       clk,
  input  logic       por_rst,
  input  logic       smr_pulse,
  input  logic       ms_tick,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       kick,
  input  logic       halt_st,
  input  logic       stop_st,
  output logic       wdt_rst_req,
  output logic       smr_flag
);
  localparam int unsigned MAXT = max7(TICKS_0, TICKS_1, TICKS_2, TICKS_3,
                                      TICKS_4, TICKS_5, TICKS_6);
  localparam int CW = $clog2(MAXT + 1);
  localparam int unsigned TAB [NPER] = '{TICKS_0, TICKS_1, TICKS_2, TICKS_3,
                                         TICKS_4, TICKS_5, TICKS_6};

  per_idx_t      per_idx;
  logic          halt_en, stop_en, step;
  logic [CW-1:0] lim_tab [NPER];
  logic [CW-1:0] limit;

  genvar g;
  generate
    for (g = 0; g < NPER; g++) begin : g_lim
      assign lim_tab[g] = CW'(TAB[g]);
    end
  endgenerate

  assign limit = lim_tab[per_idx];
  assign step  = ms_tick && (!halt_st || halt_en) && (!stop_st || stop_en);

  wdog_mode_reg u_mode (
    .clk     (clk),
    .rst     (por_rst || wdt_rst_req),
    .we      (mode_we),
    .wdata   (mode_wdata),
    .per_idx (per_idx),
    .halt_en (halt_en),
    .stop_en (stop_en)
  );

  wdog_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (por_rst),
    .clr    (kick || mode_we),
    .step   (step),
    .limit  (limit),
    .expire (wdt_rst_req)
  );

  wdog_status u_stat (
    .clk     (clk),
    .por     (por_rst),
    .wdt_evt (wdt_rst_req),
    .smr_evt (smr_pulse),
    .flag    (smr_flag)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic clk,
  input logic por_rst,
  input logic ms_tick,
  input logic kick,
  input logic mode_we,
  input logic smr_pulse,
  input logic wdt_rst_req,
  input logic smr_flag
);
  // R1
  por_state_chk: assert property (@(posedge clk)
    por_rst |=> (!wdt_rst_req && !smr_flag));
  // R9
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (por_rst)
    wdt_rst_req |=> !wdt_rst_req);
  // R9
  req_clears_flag_chk: assert property (@(posedge clk) disable iff (por_rst)
    wdt_rst_req |=> !smr_flag);
  // R11
  tick_cause_chk: assert property (@(posedge clk) disable iff (por_rst)
    wdt_rst_req |-> $past(ms_tick));
  // R7
  kick_clear_chk: assert property (@(posedge clk) disable iff (por_rst)
    kick |=> !wdt_rst_req);
  // R8
  write_clear_chk: assert property (@(posedge clk) disable iff (por_rst)
    mode_we |=> !wdt_rst_req);
  // R10
  smr_set_chk: assert property (@(posedge clk) disable iff (por_rst)
    (smr_pulse && !wdt_rst_req) |=> smr_flag);
endmodule

bind wdog_top wdog_chk u_wdog_chk (
  .clk         (clk),
  .por_rst     (por_rst),
  .ms_tick     (ms_tick),
  .kick        (kick),
  .mode_we     (mode_we),
  .smr_pulse   (smr_pulse),
  .wdt_rst_req (wdt_rst_req),
  .smr_flag    (smr_flag)
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  localparam int unsigned TT [7] = '{3, 4, 5, 6, 7, 8, 9};

  logic clk = 1'b0;
  logic por_rst = 1'b1, smr_pulse = 1'b0, ms_tick = 1'b0, mode_we = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic kick = 1'b0, halt_st = 1'b0, stop_st = 1'b0;
  logic wdt_rst_req, smr_flag;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wdog_top #(.TICKS_0(TT[0]), .TICKS_1(TT[1]), .TICKS_2(TT[2]), .TICKS_3(TT[3]),
             .TICKS_4(TT[4]), .TICKS_5(TT[5]), .TICKS_6(TT[6])) dut (
    .clk(clk), .por_rst(por_rst), .smr_pulse(smr_pulse), .ms_tick(ms_tick),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .kick(kick),
    .halt_st(halt_st), .stop_st(stop_st),
    .wdt_rst_req(wdt_rst_req), .smr_flag(smr_flag));

  // Behavioural reference model
  int m_mode = 13, m_cnt = 0, m_req = 0, m_flag = 0;

  function automatic int period_of(input int mode);
    int hi, ones;
    hi = (mode >> 4) & 7;
    ones = 0;
    for (int b = 0; b < 3; b++) if ((hi >> b) & 1) ones++;
    if (ones == 1) return (hi == 1) ? TT[4] : (hi == 2) ? TT[5] : TT[6];
    return TT[mode & 3];
  endfunction

  always @(posedge clk) begin
    int n_mode, n_cnt, n_req, n_flag;
    bit run;
    cycles++;
    if (por_rst) begin
      n_mode = 13; n_cnt = 0; n_req = 0; n_flag = 0;
    end else begin
      n_mode = m_req ? 13 : (mode_we ? (mode_wdata & 8'h7F) : m_mode);
      n_flag = m_req ? 0 : (smr_pulse ? 1 : m_flag);
      n_req = 0;
      n_cnt = m_cnt;
      run = ms_tick && !(halt_st && !((m_mode >> 2) & 1)) &&
            !(stop_st && !((m_mode >> 3) & 1));
      if (kick || mode_we) n_cnt = 0;
      else if (run) begin
        n_cnt = m_cnt + 1;
        if (n_cnt >= period_of(m_mode)) begin n_cnt = 0; n_req = 1; end
      end
    end
    m_mode = n_mode; m_cnt = n_cnt; m_req = n_req; m_flag = n_flag;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(wdt_rst_req === m_req[0], {cur_req, " model req"}, int'(wdt_rst_req), m_req);
    check(smr_flag === m_flag[0], {cur_req, " model flag"}, int'(smr_flag), m_flag);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_we = 1'b1; mode_wdata = v; @(negedge clk); mode_we = 1'b0;
  endtask

  // Apply ticks until a reset request appears; return ticks used.
  task automatic run_to_expiry(output int used);
    used = 0;
    for (int i = 0; i < 200; i++) begin
      ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
      used++;
      if (wdt_rst_req) return;
      @(negedge clk);
    end
    used = -1;
  endtask

  task automatic measure(input logic [7:0] mode, input int exp, input string req);
    int u;
    cur_req = req;
    write_mode(mode);
    run_to_expiry(u);
    check(u == exp, {req, " period"}, u, exp);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int u;
    idle(3);
    por_rst = 1'b0;
    @(negedge clk);
    // R1 reset state and 0x0D default period
    check(wdt_rst_req == 1'b0, "R1 req", int'(wdt_rst_req), 0);
    check(smr_flag == 1'b0, "R1 flag", int'(smr_flag), 0);
    cur_req = "R1";
    run_to_expiry(u);
    check(u == TT[1], "R1 default period", u, TT[1]);
    @(negedge clk);

    // R2 fine codes
    measure(8'h0C, TT[0], "R2");
    measure(8'h0D, TT[1], "R2");
    measure(8'h0E, TT[2], "R2");
    measure(8'h0F, TT[3], "R2");
    // R3 coarse codes, fine bits varied
    measure(8'h1F, TT[4], "R3");
    measure(8'h2C, TT[5], "R3");
    measure(8'h4E, TT[6], "R3");
    // R4 multi-bit coarse fallback
    measure(8'h3C, TT[0], "R4");
    measure(8'h5E, TT[2], "R4");
    measure(8'h7F, TT[3], "R4");
    // R8 bit 7 ignored
    measure(8'h8D, TT[1], "R8");

    // R5 HALT hold
    cur_req = "R5";
    write_mode(8'h09);
    halt_st = 1'b1; ticks(20);
    check(wdt_rst_req == 1'b0, "R5 hold in halt", int'(wdt_rst_req), 0);
    halt_st = 1'b0;
    run_to_expiry(u);
    check(u == TT[1], "R5 resume", u, TT[1]);
    @(negedge clk);
    write_mode(8'h0D); halt_st = 1'b1;
    run_to_expiry(u);
    check(u == TT[1], "R5 count in halt", u, TT[1]);
    halt_st = 1'b0; @(negedge clk);

    // R6 STOP hold
    cur_req = "R6";
    write_mode(8'h04);
    stop_st = 1'b1; ticks(20);
    check(wdt_rst_req == 1'b0, "R6 hold in stop", int'(wdt_rst_req), 0);
    stop_st = 1'b0;
    run_to_expiry(u);
    check(u == TT[0], "R6 resume", u, TT[0]);
    @(negedge clk);

    // R7 kick mid-period
    cur_req = "R7";
    write_mode(8'h0F);
    ticks(TT[3] - 1);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    run_to_expiry(u);
    check(u == TT[3], "R7 full period after kick", u, TT[3]);
    @(negedge clk);

    // R8 write mid-period
    cur_req = "R8";
    write_mode(8'h0E);
    ticks(TT[2] - 1);
    write_mode(8'h0E);
    run_to_expiry(u);
    check(u == TT[2], "R8 full period after write", u, TT[2]);
    @(negedge clk);

    // R10 smr keeps mode; R9 expiry clears flag and restores 0x0D
    cur_req = "R10";
    write_mode(8'h20);
    smr_pulse = 1'b1; @(negedge clk); smr_pulse = 1'b0;
    check(smr_flag == 1'b1, "R10 flag set", int'(smr_flag), 1);
    run_to_expiry(u);
    check(u == TT[5], "R10 mode kept", u, TT[5]);
    @(negedge clk);
    cur_req = "R9";
    check(wdt_rst_req == 1'b0, "R9 single-cycle req", int'(wdt_rst_req), 0);
    check(smr_flag == 1'b0, "R9 flag cleared", int'(smr_flag), 0);
    run_to_expiry(u);
    check(u == TT[1], "R9 mode restored", u, TT[1]);
    @(negedge clk);

    // R11 no ticks, no expiry
    cur_req = "R11";
    idle(50);
    check(wdt_rst_req == 1'b0, "R11 idle without ticks", int'(wdt_rst_req), 0);

    // R1 power-on reset clears flag
    cur_req = "R1";
    smr_pulse = 1'b1; @(negedge clk); smr_pulse = 1'b0;
    por_rst = 1'b1; idle(2); por_rst = 1'b0; @(negedge clk);
    check(smr_flag == 1'b0, "R1 flag after reset", int'(smr_flag), 0);

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule